// File: doc/BRIEF.md
# Two-Source Interrupt Acceptor with Return-Address Stack

This block takes interrupt events from two sources, a timer overflow pulse and the rising edge of an external input. Each event is held in its own request flag. A small accept state machine waits one instruction boundary after a request appears. At the next boundary where the global enable flag is set, it issues a one-cycle take pulse with a fixed vector for the chosen source. In that take cycle the current program counter is pushed into a four-entry shift stack. The take also clears the enable flag and the serviced request flag. The status flag is not touched.

A return-from-interrupt command pops the stack and sets the enable flag in the same cycle. The restored address is always visible as the top stack entry. Software keeps explicit set and clear commands for the enable flag and a clear command for each request flag. Saving any other register is left to software.

The accept machine has four states. `ST_IDLE` means nothing is pending. `ST_DELAY` means a request is latched and the delaying boundary has not yet been seen. `ST_READY` means the delay has elapsed. `ST_TAKE` is the one-cycle take. Its transitions are:
- latch: `ST_IDLE`→`ST_DELAY`, on any request flag set.
- withdraw: `ST_DELAY`/`ST_READY`→`ST_IDLE`, when all request flags are cleared.
- age: `ST_DELAY`→`ST_READY`, on a boundary.
- accept: `ST_READY`→`ST_TAKE`, on a boundary with the enable flag set.
- done: `ST_TAKE`→`ST_IDLE`, unconditionally.

Top module: `irq_two_source_ctl`

## Requirements
- R1: After reset, take_o is 0, vector_o is 0, ie_o is 0, req_o is 2'b00 and ret_pc_o is 0.
- R2: req_o[0] is the timer flag and req_o[1] is the input flag. Each flag is set one cycle after its event. A clear that arrives in the same cycle as an event leaves the flag set. A clear that arrives without an event drops the flag one cycle later.
- R3: A boundary in the cycle the request flag is first seen does not count. The first boundary after that only ages the request. The take pulse appears in the cycle after the second boundary, and it lasts exactly one cycle.
- R4: No take occurs while ie_o is 0. A pending request stays pending and is taken at the first boundary after ie_o becomes 1, provided it has already aged.
- R5: During the take cycle, vector_o is 10'h03F for the timer (bank 0, page 0, address 0x3F) and 10'h07F for the input (bank 0, page 1, address 0x3F). At all other times vector_o is 0.
- R6: When both flags are set at the accepting boundary, the timer is taken first. The input request stays pending and is taken later.
- R7: One cycle after the take cycle, ie_o is 0 and the serviced flag is clear. The other flag is kept.
- R8: The take pushes pc_i, as seen in the take cycle, onto the stack. Each entry shifts one place deeper and the deepest entry is lost. ret_pc_o shows the top entry.
- R9: rti_i pops the stack, so ret_pc_o shows the next entry one cycle later. The deepest entry keeps its value. ie_o becomes 1 in the same step.
- R10: If rti_i arrives in a take cycle, the push happens, no pop happens, and ie_o ends at 0.
- R11: Only a rising edge of ext_irq_i sets the input flag. Holding the input high after the flag is cleared does not set it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_ovf_i | input | 1 | Timer overflow event, one cycle per overflow |
| ext_irq_i | input | 1 | External interrupt input; its rising edge is the event |
| req_clr_i | input | 2 | Request clear commands, [0] timer and [1] input |
| ie_set_i | input | 1 | Set the enable flag |
| ie_clr_i | input | 1 | Clear the enable flag |
| boundary_i | input | 1 | Instruction boundary strobe |
| rti_i | input | 1 | Return-from-interrupt: pop and enable |
| pc_i | input | 10 | Current program counter |
| take_o | output | 1 | Forced call is taken this cycle |
| vector_o | output | 10 | Call target during take, else 0 |
| ret_pc_o | output | 10 | Top stack entry (return address) |
| ie_o | output | 1 | Enable flag |
| req_o | output | 2 | Request flags, [0] timer and [1] input |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a source's event and its clear command. The bench drives an overflow pulse, and separately a fresh input edge, together with the matching clear. It then judges req_o one cycle later, which must still be set, and checks that a lone clear does drop the flag. The second pair is the take cycle and a return command. The bench raises rti_i exactly in the take cycle. It expects the new PC on top of the stack, the deeper entries untouched, and the enable flag low. Randomly mixed take and return sequences, checked against a bench stack model, cover the shift and the lost deepest entry.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_SRC = 2;
    localparam int SRC_TMR = 0;
    localparam int SRC_INP = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_READY = 2'd2,
        ST_TAKE  = 2'd3
    } acc_state_e;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    output logic req_o
);
    logic req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            req_q <= 1'b0;
        else if (evt_i)
            req_q <= 1'b1;
        else if (clr_i)
            req_q <= 1'b0;
    end

    assign req_o = req_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> req_q); // R2
    AST_CLR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !evt_i) |=> !req_q); // R2
endmodule

// File: rtl/irq_pc_stack.sv
module irq_pc_stack #(
    parameter int PC_W  = 10,
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_i,
    input  logic            pop_i,
    input  logic [PC_W-1:0] pc_i,
    output logic [PC_W-1:0] top_o
);
    localparam int LAST = DEPTH - 1;

    logic [PC_W-1:0] st_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [PC_W-1:0] from_above;
        logic [PC_W-1:0] from_below;

        if (i == 0) begin : g_first
            assign from_above = pc_i;
        end else begin : g_mid
            assign from_above = st_q[i-1];
        end

        if (i == LAST) begin : g_last
            assign from_below = st_q[i];
        end else begin : g_inner
            assign from_below = st_q[i+1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                st_q[i] <= '0;
            else if (push_i)
                st_q[i] <= from_above;
            else if (pop_i)
                st_q[i] <= from_below;
        end
    end

    assign top_o = st_q[0];

    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (top_o == $past(pc_i))); // R8
    AST_PUSH_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (st_q[1] == $past(st_q[0]))); // R8
    AST_POP_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> (top_o == $past(st_q[1]))); // R9
    AST_POP_HOLD_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> $stable(st_q[LAST])); // R9
endmodule

// File: rtl/irq_accept_fsm.sv
module irq_accept_fsm
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               boundary_i,
    input  logic               ie_set_i,
    input  logic               ie_clr_i,
    input  logic               rti_i,
    output logic               take_o,
    output logic               sel_inp_o,
    output logic [NUM_SRC-1:0] svc_clr_o,
    output logic               ie_o
);
    acc_state_e state_q, state_d;
    logic       sel_inp_q, sel_inp_d;
    logic       ie_q;
    logic       any_req;

    assign any_req = |req_i;

    always_comb begin
        state_d   = state_q;
        sel_inp_d = sel_inp_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any_req) state_d = ST_DELAY;
            end
            ST_DELAY: begin
                if (!any_req)       state_d = ST_IDLE;
                else if (boundary_i) state_d = ST_READY;
            end
            ST_READY: begin
                if (!any_req) begin
                    state_d = ST_IDLE;
                end else if (boundary_i && ie_q) begin
                    state_d   = ST_TAKE;
                    sel_inp_d = !req_i[SRC_TMR];
                end
            end
            ST_TAKE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            sel_inp_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            sel_inp_q <= sel_inp_d;
        end
    end

    always_comb begin
        take_o    = 1'b0;
        sel_inp_o = 1'b0;
        svc_clr_o = '0;
        unique case (state_q)
            ST_TAKE: begin
                take_o    = 1'b1;
                sel_inp_o = sel_inp_q;
                svc_clr_o[SRC_TMR] = !sel_inp_q;
                svc_clr_o[SRC_INP] = sel_inp_q;
            end
            ST_IDLE, ST_DELAY, ST_READY: begin
                take_o = 1'b0;
            end
            default: take_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ie_q <= 1'b0;
        else if (take_o)
            ie_q <= 1'b0;
        else if (ie_set_i || rti_i)
            ie_q <= 1'b1;
        else if (ie_clr_i)
            ie_q <= 1'b0;
    end

    assign ie_o = ie_q;

    AST_TAKE_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(ie_q)); // R4
    AST_TAKE_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(boundary_i)); // R3
    AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o); // R3
    AST_TAKE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !ie_q); // R7
    AST_TIMER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (sel_inp_o == !$past(req_i[SRC_TMR]))); // R6
    AST_RTI_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (rti_i && !take_o) |=> ie_q); // R9
endmodule

// File: rtl/irq_two_source_ctl.sv
module irq_two_source_ctl
    import irq_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int PAGE_W    = 2,
    parameter int ADDR_W    = 6,
    parameter int STACK_D   = 4,
    parameter int VEC_ADDR  = 63,
    parameter int TMR_PAGE  = 0,
    parameter int INP_PAGE  = 1,
    parameter int VEC_BANK  = 0,
    parameter int PC_W      = BANK_W + PAGE_W + ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tmr_ovf_i,
    input  logic               ext_irq_i,
    input  logic [NUM_SRC-1:0] req_clr_i,
    input  logic               ie_set_i,
    input  logic               ie_clr_i,
    input  logic               boundary_i,
    input  logic               rti_i,
    input  logic [PC_W-1:0]    pc_i,
    output logic               take_o,
    output logic [PC_W-1:0]    vector_o,
    output logic [PC_W-1:0]    ret_pc_o,
    output logic               ie_o,
    output logic [NUM_SRC-1:0] req_o
);
    localparam logic [PC_W-1:0] VEC_TMR =
        {BANK_W'(VEC_BANK), PAGE_W'(TMR_PAGE), ADDR_W'(VEC_ADDR)};
    localparam logic [PC_W-1:0] VEC_INP =
        {BANK_W'(VEC_BANK), PAGE_W'(INP_PAGE), ADDR_W'(VEC_ADDR)};

    logic               ext_prev_q;
    logic [NUM_SRC-1:0] evt;
    logic [NUM_SRC-1:0] svc_clr;
    logic [NUM_SRC-1:0] req;
    logic               take;
    logic               sel_inp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_prev_q <= 1'b0;
        else        ext_prev_q <= ext_irq_i;
    end

    assign evt[SRC_TMR] = tmr_ovf_i;
    assign evt[SRC_INP] = ext_irq_i && !ext_prev_q;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        irq_req_latch u_latch (
            .clk   (clk),
            .rst_n (rst_n),
            .evt_i (evt[s]),
            .clr_i (req_clr_i[s] || svc_clr[s]),
            .req_o (req[s])
        );
    end

    irq_accept_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .boundary_i (boundary_i),
        .ie_set_i   (ie_set_i),
        .ie_clr_i   (ie_clr_i),
        .rti_i      (rti_i),
        .take_o     (take),
        .sel_inp_o  (sel_inp),
        .svc_clr_o  (svc_clr),
        .ie_o       (ie_o)
    );

    irq_pc_stack #(.PC_W(PC_W), .DEPTH(STACK_D)) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (take),
        .pop_i  (rti_i && !take),
        .pc_i   (pc_i),
        .top_o  (ret_pc_o)
    );

    assign take_o   = take;
    assign vector_o = !take ? '0 : (sel_inp ? VEC_INP : VEC_TMR);
    assign req_o    = req;

    AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (vector_o == VEC_TMR || vector_o == VEC_INP)); // R5
    AST_VEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (vector_o == '0)); // R5
    AST_SERVICED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vector_o == VEC_TMR && !tmr_ovf_i) |=> !req_o[SRC_TMR]); // R7
    AST_LEVEL_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o[SRC_INP] && ext_prev_q && ext_irq_i) |=> !req_o[SRC_INP]); // R11
endmodule

// File: tb/irq_two_source_ctl_bench.sv
`timescale 1ns/1ps
module irq_two_source_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tmr_ovf_i = 1'b0, ext_irq_i = 1'b0;
    logic [1:0] req_clr_i = 2'b00;
    logic       ie_set_i = 1'b0, ie_clr_i = 1'b0, boundary_i = 1'b0, rti_i = 1'b0;
    logic [9:0] pc_i = '0;
    logic       take_o, ie_o;
    logic [9:0] vector_o, ret_pc_o;
    logic [1:0] req_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [9:0] mst [4];

    always #2.5 clk = ~clk;

    irq_two_source_ctl u_irq_two_source_ctl (
        .clk(clk), .rst_n(rst_n), .tmr_ovf_i(tmr_ovf_i), .ext_irq_i(ext_irq_i),
        .req_clr_i(req_clr_i), .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i),
        .boundary_i(boundary_i), .rti_i(rti_i), .pc_i(pc_i), .take_o(take_o),
        .vector_o(vector_o), .ret_pc_o(ret_pc_o), .ie_o(ie_o), .req_o(req_o)
    );

    function automatic logic [9:0] exp_vec(input int src);
        return (src == 0) ? 10'h03F : 10'h07F;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic model_push(input logic [9:0] pc);
        for (int i = 3; i > 0; i--) mst[i] = mst[i-1];
        mst[0] = pc;
    endtask

    task automatic model_pop();
        for (int i = 0; i < 3; i++) mst[i] = mst[i+1];
    endtask

    task automatic pulse_ie();
        ie_set_i = 1'b1; step(); ie_set_i = 1'b0;
    endtask

    task automatic do_irq(input int src, input logic [9:0] pc, input bit rti_in_take);
        pc_i = pc;
        if (src == 0) tmr_ovf_i = 1'b1; else ext_irq_i = 1'b1;
        step();
        tmr_ovf_i = 1'b0;
        step();
        boundary_i = 1'b1;
        step();
        check("R3 no take after first boundary", {31'd0, take_o}, 32'd0);
        step();
        boundary_i = 1'b0;
        check("R3 take after second boundary", {31'd0, take_o}, 32'd1);
        check("R5 vector", {22'd0, vector_o}, {22'd0, exp_vec(src)});
        rti_i = rti_in_take;
        step();
        rti_i = 1'b0;
        ext_irq_i = 1'b0;
        model_push(pc);
        check("R3 take lasts one cycle", {31'd0, take_o}, 32'd0);
        check("R7 ie cleared by take", {31'd0, ie_o}, 32'd0);
        check("R7 serviced flag cleared", {31'd0, req_o[src]}, 32'd0);
        check("R8 pushed pc on top", {22'd0, ret_pc_o}, {22'd0, pc});
    endtask

    task automatic do_rti();
        check("R9 top before pop", {22'd0, ret_pc_o}, {22'd0, mst[0]});
        rti_i = 1'b1; step(); rti_i = 1'b0;
        model_pop();
        check("R9 top after pop", {22'd0, ret_pc_o}, {22'd0, mst[0]});
        check("R9 ie set by return", {31'd0, ie_o}, 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) mst[i] = '0;
        void'($urandom(32'd20240611));
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 take", {31'd0, take_o}, 32'd0);
        check("R1 vector", {22'd0, vector_o}, 32'd0);
        check("R1 ie", {31'd0, ie_o}, 32'd0);
        check("R1 req", {30'd0, req_o}, 32'd0);
        check("R1 stack top", {22'd0, ret_pc_o}, 32'd0);

        // R4: disabled, request waits through many boundaries
        tmr_ovf_i = 1'b1; step(); tmr_ovf_i = 1'b0;
        boundary_i = 1'b1;
        for (int k = 0; k < 6; k++) begin
            step();
            check("R4 no take while disabled", {31'd0, take_o}, 32'd0);
        end
        boundary_i = 1'b0;
        check("R4 request kept", {31'd0, req_o[0]}, 32'd1);
        ie_set_i = 1'b1; step(); ie_set_i = 1'b0;
        boundary_i = 1'b1; step(); boundary_i = 1'b0;
        check("R4 aged request taken once enabled", {31'd0, take_o}, 32'd1);
        step();
        model_push(pc_i);
        check("R7 timer flag cleared", {30'd0, req_o}, 32'd0);

        // R2: event and clear in the same cycle
        tmr_ovf_i = 1'b1; req_clr_i = 2'b01; step();
        tmr_ovf_i = 1'b0; req_clr_i = 2'b00;
        check("R2 timer set wins", {31'd0, req_o[0]}, 32'd1);
        ext_irq_i = 1'b1; req_clr_i = 2'b10; step();
        req_clr_i = 2'b00;
        check("R2 input set wins", {31'd0, req_o[1]}, 32'd1);
        req_clr_i = 2'b11; step(); req_clr_i = 2'b00;
        check("R2 lone clear drops flags", {30'd0, req_o}, 32'd0);
        // R11: input held high does not set again
        for (int k = 0; k < 3; k++) begin
            step();
            check("R11 level does not set", {31'd0, req_o[1]}, 32'd0);
        end
        ext_irq_i = 1'b0; step();
        check("R11 falling edge ignored", {31'd0, req_o[1]}, 32'd0);

        // R3 R5 R7 R8 both sources
        pulse_ie();
        do_irq(0, 10'h155, 1'b0);
        pulse_ie();
        do_irq(1, 10'h2AA, 1'b0);

        // R6: both at once, timer first
        pulse_ie();
        tmr_ovf_i = 1'b1; ext_irq_i = 1'b1; pc_i = 10'h101; step();
        tmr_ovf_i = 1'b0; step();
        boundary_i = 1'b1; step(); step(); boundary_i = 1'b0;
        check("R6 timer taken first", {22'd0, vector_o}, 32'h03F);
        step();
        model_push(10'h101);
        check("R6 input still pending", {30'd0, req_o}, 32'd2);
        ext_irq_i = 1'b0;
        pulse_ie();
        pc_i = 10'h202;
        boundary_i = 1'b1;
        begin
            int n = 0;
            while (!take_o && n < 6) begin step(); n++; end
        end
        boundary_i = 1'b0;
        check("R6 input taken later", {22'd0, vector_o}, 32'h07F);
        step();
        model_push(10'h202);
        check("R6 stack top", {22'd0, ret_pc_o}, 32'h202);

        // R10: return command in the take cycle
        pulse_ie();
        do_irq(0, 10'h0C3, 1'b1);
        check("R10 deeper entry untouched", {22'd0, mst[1]}, 32'h202);

        // R8 R9: overflow of the four-entry stack
        for (int k = 1; k <= 5; k++) begin
            pulse_ie();
            do_irq(0, 10'(k * 16 + 3), 1'b0);
        end
        begin
            logic [9:0] tops [5] = '{10'h053, 10'h043, 10'h033, 10'h023, 10'h023};
            for (int k = 0; k < 5; k++) begin
                check("R8 top after overflow", {22'd0, ret_pc_o}, {22'd0, tops[k]});
                do_rti();
            end
        end

        // random mix of takes and returns
        for (int it = 0; it < 60; it++) begin
            int op = int'($urandom % 3);
            if (op < 2) begin
                pulse_ie();
                do_irq(int'($urandom % 2), 10'($urandom), 1'b0);
            end else begin
                do_rti();
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule